// File: doc/BRIEF.md
# Selectable Reference Frequency Divider

This block turns a free-running reference clock into a low-rate comparison strobe for a phase-locked loop. A fixed divide-by-100 prescaler comes first. A second stage follows it, and its ratio is picked by a 3-bit code. The overall ratios are not monotonic in the code. Codes 000 to 011 give 1600, 800, 400 and 200. Codes 100 to 111 give 2000, 1000, 500 and 100. A monitor square wave with a period of 100 reference cycles is also produced, which is useful when trimming the reference crystal.

The code is loaded over a three-wire serial bus: a data line, a shift clock and a load strobe. A 19-bit word is shifted in, most significant bit first. The first three bits sent form the select code, and the remaining sixteen belong to a neighbouring divider, so this block discards them. A shifted word has no effect until the load strobe copies its code into a holding register. The new ratio then starts at the next prescaler boundary, with the second stage restarted from zero.

The serial lines are slow control pins with no stream semantics, so no valid/ready handshake is used. They are synchronised into the reference clock domain. The shift clock and the load strobe act on their rising edges. The data line must be stable around each shift clock edge for a few reference cycles.

Top module: `refdiv_top`

## Requirements
- R1: Every comparison pulse falls on a prescaler boundary. Pulses are seen only at reference-cycle counts since reset that are multiples of 100.
- R2: Select codes 000, 001, 010 and 011 give a steady pulse spacing of 1600, 800, 400 and 200 reference cycles.
- R3: Select codes 100, 101, 110 and 111 give a steady pulse spacing of 2000, 1000, 500 and 100 reference cycles.
- R4: The monitor output is low after reset. It first rises 50 cycles after reset and then toggles every 50 reference cycles.
- R5: The shift register samples the data line on each rising edge of the shift clock. After 19 bits, the first three sent (code bit 2 first) are the select code. The last 16 bits do not change the ratio.
- R6: A shifted word without a rising edge on the load strobe leaves the pulse spacing unchanged.
- R7: A loaded code takes effect at the next prescaler boundary. The second stage restarts from zero, so the gap that spans the change is longer than the new period. After the change, gaps equal the new period exactly.
- R8: The comparison pulse is high for exactly one reference cycle.
- R9: Reset selects code 000 and holds both outputs low. The first comparison pulse is seen 1600 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; rising edge copies the code into the holding register |
| cmp_pulse | output | 1 | One-cycle comparison pulse |
| mon_out | output | 1 | Square wave at one hundredth of the reference rate |

## Verification
The bench walks through all eight codes in an order that alternates short and long ratios. This catches a swapped or monotonic ratio table, which would give the wrong spacing for one of the upper codes. Each loaded word carries a 16-bit tail chosen so that a design taking the wrong three bits would pick a different ratio. A word is also shifted in without its load strobe, to catch a design whose ratio follows the shift register directly. At every code change the bench measures the gap that spans the change. A design that switches ratio in mid-count would produce a gap shorter than the new period, or a pulse off the 100-cycle grid.

// File: rtl/refdiv_pkg.sv
`timescale 1ns/1ps
package refdiv_pkg;
  parameter int CODE_W = 3;
  parameter int MAX_S2 = 20;

  // Second-stage ratio per select code (total ratio = 100 * this)
  function automatic int unsigned stage2_ratio(input logic [CODE_W-1:0] code);
    case (code)
      3'b000:  return 16;
      3'b001:  return 8;
      3'b010:  return 4;
      3'b011:  return 2;
      3'b100:  return 20;
      3'b101:  return 10;
      3'b110:  return 5;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/refdiv_sync.sv
`timescale 1ns/1ps
module refdiv_sync #(
  parameter int W = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/refdiv_loader.sv
`timescale 1ns/1ps
module refdiv_loader
  import refdiv_pkg::*;
#(
  parameter int WORD_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              sload_s,
  output logic [CODE_W-1:0] hold_code,
  output logic              hold_upd
);
  logic [WORD_W-1:0] shreg;
  logic              sclk_q, sload_q;
  logic              sclk_rise, sload_rise;

  assign sclk_rise  = sclk_s & ~sclk_q;
  assign sload_rise = sload_s & ~sload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sload_q <= 1'b0;
      shreg   <= '0;
    end else begin
      sclk_q  <= sclk_s;
      sload_q <= sload_s;
      if (sclk_rise) shreg <= {shreg[WORD_W-2:0], sdat_s};
    end
  end

  // Code occupies the top bits: the first ones shifted in
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_code <= '0;
      hold_upd  <= 1'b0;
    end else begin
      hold_upd <= sload_rise;
      if (sload_rise) hold_code <= shreg[WORD_W-1 -: CODE_W];
    end
  end
endmodule

// File: rtl/refdiv_prescale.sv
`timescale 1ns/1ps
module refdiv_prescale #(
  parameter int PRE_DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic mon
);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam int HALF  = PRE_DIV / 2;

  logic [PRE_W-1:0] pcnt;

  assign tick = (pcnt == PRE_W'(PRE_DIV-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      mon  <= 1'b0;
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick || pcnt == PRE_W'(HALF-1)) mon <= ~mon;
    end
  end
endmodule

// File: rtl/refdiv_stage2.sv
`timescale 1ns/1ps
module refdiv_stage2
  import refdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] new_code,
  input  logic              new_upd,
  output logic [CODE_W-1:0] act_code,
  output logic              pulse
);
  localparam int S2_W = $clog2(MAX_S2 + 1);

  logic [S2_W-1:0] s2cnt, lim;
  logic            pend;

  assign lim = S2_W'(stage2_ratio(act_code) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= '0;
      s2cnt    <= '0;
      pend     <= 1'b0;
      pulse    <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (new_upd) pend <= 1'b1;
      if (tick) begin
        if (pend || new_upd) begin
          act_code <= new_code;
          s2cnt    <= '0;
          pend     <= 1'b0;
        end else if (s2cnt == lim) begin
          s2cnt <= '0;
          pulse <= 1'b1;
        end else begin
          s2cnt <= s2cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/refdiv_top.sv
`timescale 1ns/1ps
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int PRE_DIV     = 100,
  parameter int WORD_W      = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_data,
  input  logic ser_load,
  output logic cmp_pulse,
  output logic mon_out
);
  logic [2:0]        ser_s;
  logic              pre_tick;
  logic [CODE_W-1:0] hold_code, act_code;
  logic              hold_upd;

  refdiv_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_ref), .rst_n(rst_n),
    .d({ser_load, ser_data, ser_clk}), .q(ser_s)
  );

  refdiv_loader #(.WORD_W(WORD_W)) u_load (
    .clk(clk_ref), .rst_n(rst_n),
    .sclk_s(ser_s[0]), .sdat_s(ser_s[1]), .sload_s(ser_s[2]),
    .hold_code(hold_code), .hold_upd(hold_upd)
  );

  refdiv_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk_ref), .rst_n(rst_n), .tick(pre_tick), .mon(mon_out)
  );

  refdiv_stage2 u_s2 (
    .clk(clk_ref), .rst_n(rst_n), .tick(pre_tick),
    .new_code(hold_code), .new_upd(hold_upd),
    .act_code(act_code), .pulse(cmp_pulse)
  );
endmodule

// File: rtl/refdiv_chk.sv
`timescale 1ns/1ps
module refdiv_chk #(
  parameter int PRE_DIV = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmp_pulse,
  input logic       mon_out,
  input logic       pre_tick,
  input logic [2:0] act_code,
  input logic [2:0] hold_code,
  input logic       hold_upd
);
  localparam int PRE_W = $clog2(PRE_DIV) + 1;
  localparam int HALF  = PRE_DIV / 2;

  logic             mon_q;
  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_q <= 1'b0;
      cnt   <= '0;
    end else begin
      mon_q <= mon_out;
      cnt   <= (mon_out != mon_q) ? PRE_W'(1) : cnt + 1'b1;
    end
  end

  a_r8_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse);

  a_r1_pulse_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |-> $past(pre_tick));

  a_r7_switch_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_code) |-> $past(pre_tick));

  a_r6_hold_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_code) |-> hold_upd);

  a_r4_mon_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_out != mon_q) |-> (cnt == PRE_W'(HALF)));
endmodule

bind refdiv_top refdiv_chk #(.PRE_DIV(PRE_DIV)) u_chk (
  .clk(clk_ref), .rst_n(rst_n), .cmp_pulse(cmp_pulse), .mon_out(mon_out),
  .pre_tick(pre_tick), .act_code(act_code), .hold_code(hold_code),
  .hold_upd(hold_upd)
);

// File: tb/refdiv_top_test.sv
`timescale 1ns/1ps
module refdiv_top_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic cmp_pulse, mon_out;

  int checks = 0, fails = 0;
  int cyc = 0, since = 0, last_gap = 0, npulse = 0;
  int exp_q[$];
  int mon_last = 0;
  logic mon_prev = 1'b0, mon_seen = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  refdiv_top uut (
    .clk_ref(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .cmp_pulse(cmp_pulse), .mon_out(mon_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int period_of(input logic [2:0] code);
    case (code)
      3'd0: return 1600; 3'd1: return 800; 3'd2: return 400; 3'd3: return 200;
      3'd4: return 2000; 3'd5: return 1000; 3'd6: return 500; default: return 100;
    endcase
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      since++;
      if (cmp_pulse) begin
        npulse++;
        if (npulse == 1) check(cyc == 1600, "R9 first pulse", cyc, 1600);
        check(cyc % 100 == 0, "R1 pulse on grid", cyc % 100, 0);
        if (exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          check(since == e, (e >= 1600 && e != 2000) || e == 800 || e == 400 || e == 200
                ? "R2 period" : "R3 period", since, e);
        end
        last_gap = since;
        since = 0;
      end
      if (mon_out != mon_prev) begin
        if (!mon_seen) check(cyc == 50 && mon_out, "R4 first rise", cyc, 50);
        else check(cyc - mon_last == 50, "R4 half period", cyc - mon_last, 50);
        mon_seen = 1'b1;
        mon_last = cyc;
        mon_prev = mon_out;
      end
    end
  end

  task automatic wait_pulse();
    do begin @(negedge clk); #1; end while (!cmp_pulse);
  endtask

  task automatic send_word(input logic [18:0] w);
    for (int i = 18; i >= 0; i--) begin
      @(negedge clk); ser_data = w[i];
      repeat (4) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
    end
  endtask

  task automatic strobe();
    @(negedge clk); ser_load = 1'b1;
    repeat (5) @(negedge clk); ser_load = 1'b0;
  endtask

  task automatic measure(input int p, input int n);
    wait_pulse();
    for (int i = 0; i < n; i++) exp_q.push_back(p);
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  // R7: after load, find the first gap equal to the new period; the gap before it must be longer
  task automatic retune(input logic [2:0] code, input logic [15:0] tail);
    int p, prev, tries;
    p = period_of(code);
    send_word({code, tail});
    strobe();
    prev = 0; tries = 0;
    do begin
      wait_pulse();
      tries++;
      if (last_gap != p) prev = last_gap;
    end while (last_gap != p && tries < 6);
    check(last_gap == p, "R7 settles to new period", last_gap, p);
    check(prev > p, "R7 no runt at change", prev, p + 100);
    for (int i = 0; i < 2; i++) exp_q.push_back(p);
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cmp_pulse == 1'b0, "R9 pulse low in reset", int'(cmp_pulse), 0);
    check(mon_out == 1'b0, "R9 monitor low in reset", int'(mon_out), 0);
    #2 rst_n = 1'b1;
    measure(1600, 2);                         // R9 default code 000 (R2)
    // R5: tails hold the wrong code in their low bits
    retune(3'd7, 16'h0000);                   // R3
    retune(3'd3, 16'hFFFC);                   // R2
    retune(3'd4, 16'h0003);                   // R3
    retune(3'd1, 16'hAAA6);                   // R2
    retune(3'd6, 16'h5551);                   // R3
    retune(3'd2, 16'h0F05);                   // R2
    retune(3'd5, 16'hF0F2);                   // R3
    retune(3'd0, 16'hFFFF);                   // R2
    // R6: shift a new word without load; spacing stays at 1600
    send_word({3'd7, 16'h0000});
    measure(1600, 2);
    check(last_gap == 1600, "R6 no load no change", last_gap, 1600);
    strobe();
    wait_pulse(); wait_pulse();
    measure(100, 3);
    check(last_gap == 100, "R6 load applies word", last_gap, 100);
    // R8: pulse width one cycle
    wait_pulse();
    @(negedge clk); #1;
    check(cmp_pulse == 1'b0, "R8 one-cycle pulse", int'(cmp_pulse), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule